// File: doc/BRIEF.md
# Dual Configuration Image Store Controller

This block keeps two configuration images for an analog signal-conditioning path in a register model of a non-volatile store. Image A is 96 bits wide and holds the capacitor selection, a frequency-range bit, a 21-bit user signature, the gain code, the wake-up select and a readout-lock bit. Image B is 71 bits wide and holds only its own capacitor selection and frequency-range bit. A serial front end, which is not part of this block, presents a command strobe with an opcode and a 96-bit write image. The block then erases or programs an image, or copies one into a readback register.

Programming can only set bits: new data is ORed into the stored image, so an image is erased to all zeros before a fresh pattern is written. Erase and program each keep `busy` high for a parameterised number of timebase ticks, and the store changes when that time runs out. While an erase runs, the active gain is forced to the 10x code and the analog outputs are flagged to park at the reference level. On leaving reset, the wake-up select bit of A chooses which image drives the active capacitor and range outputs. The lock bit blocks every readback until image A is erased.

Top module: `cfgstore_ctrl`

## Requirements
- R1: After reset `busy`, `cmd_err`, `rd_valid`, `rd_blocked` and `park_out` are 0, and both images hold their shipped value of all zeros.
- R2: Programming ORs data into the stored image, so bits only go from 0 to 1. Opcode 3 programs A with `wr_image[95:0]`. Opcode 4 programs B with `wr_image[70:0]`, and bits 95:71 are ignored.
- R3: Opcode 1 clears every bit of A and opcode 2 clears every bit of B. The other image is unchanged.
- R4: An accepted erase or program raises `busy` on the next clock. `busy` stays high until exactly OP_TICKS clock edges with `tick` high have passed, and the store updates on the edge where `busy` falls.
- R5: Any non-zero opcode that arrives while `busy` is high is ignored and gives `cmd_err` high for exactly one cycle. Opcode 7 is undefined and behaves the same way at any time. Opcode 0 does nothing.
- R6: While an erase is busy, `act_gain` is 2'b11 (10x) and `park_out` is 1. At all other times `park_out` is 0 and `act_gain` equals A bits 93:92 (00 = 1x, 01 = 2x, 10 = 5x, 11 = 10x).
- R7: While A bit 95 (the lock) is 1, every readback returns zero with `rd_blocked` high. Only an erase of A clears the lock.
- R8: A readback of A (opcode 5) is refused, with a zero image and `rd_blocked` high, while A bit 94 (wake select) is 1. A readback of B is still allowed.
- R9: A readback (opcode 5 for A, opcode 6 for B zero-extended into bits 70:0) raises `rd_valid` for one cycle on the next clock with the image in `rd_image`. It does not change the active outputs.
- R10: On the first clock after reset, `act_sel_b` loads A bit 94 and holds it until the next reset. The active capacitor field (bits 69:0) and range bit (bit 70) come from B when it is 1 and from A otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the control logic (the store keeps its contents) |
| tick | input | 1 | Operation timebase strobe |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Opcode: 0 none, 1 erase A, 2 erase B, 3 program A, 4 program B, 5 read A, 6 read B, 7 undefined |
| wr_image | input | 96 | Program data |
| busy | output | 1 | Erase or program in progress |
| cmd_err | output | 1 | One-cycle pulse for a rejected command |
| rd_valid | output | 1 | Readback result present |
| rd_blocked | output | 1 | Readback was refused |
| rd_image | output | 96 | Readback image |
| act_caps | output | 70 | Active capacitor selection |
| act_range | output | 1 | Active frequency-range bit |
| act_gain | output | 2 | Active gain code |
| act_sel_b | output | 1 | Image B is the active image |
| park_out | output | 1 | Analog outputs are to be parked at the reference level |

## Verification
A wrong stored bit shows up in `rd_image` on the next readback, one cycle after the command, or at once on the active outputs if it lies in the active image. A timer that is off by one moves the falling edge of `busy` away from the OP_TICKS-th tick, and so moves the cycle in which the store changes. A lock or wake-select gate that is wrong shows up as an image where a zero with `rd_blocked` is expected, or the other way round. A wrong boot latch shows up as capacitor fields from the wrong image in the first cycles after reset.

// File: rtl/cfgstore_pkg.sv
package cfgstore_pkg;

  localparam int IMG_A_W  = 96;
  localparam int CAP_W    = 70;
  localparam int IMG_B_W  = CAP_W + 1;
  localparam int RANGE_BIT = CAP_W;
  localparam int SIG_LSB  = CAP_W + 1;
  localparam int SIG_W    = 21;
  localparam int GAIN_LSB = SIG_LSB + SIG_W;
  localparam int GAIN_W   = 2;
  localparam int WAKE_BIT = GAIN_LSB + GAIN_W;
  localparam int LOCK_BIT = WAKE_BIT + 1;
  localparam logic [GAIN_W-1:0] GAIN_ERASE = 2'b11;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_ERASE_A = 3'd1,
    OP_ERASE_B = 3'd2,
    OP_PROG_A  = 3'd3,
    OP_PROG_B  = 3'd4,
    OP_READ_A  = 3'd5,
    OP_READ_B  = 3'd6,
    OP_BAD     = 3'd7
  } op_e;

  function automatic logic is_long(op_e op);
    return (op == OP_ERASE_A) || (op == OP_ERASE_B) ||
           (op == OP_PROG_A)  || (op == OP_PROG_B);
  endfunction

  function automatic logic is_erase(op_e op);
    return (op == OP_ERASE_A) || (op == OP_ERASE_B);
  endfunction

  function automatic logic is_read(op_e op);
    return (op == OP_READ_A) || (op == OP_READ_B);
  endfunction

  // lock refuses everything; wake select refuses only image A
  function automatic logic read_allowed(op_e op, logic lock, logic wake);
    return !lock && !(op == OP_READ_A && wake);
  endfunction

  function automatic logic [IMG_A_W-1:0] widen_b(logic [IMG_B_W-1:0] b);
    return {{(IMG_A_W-IMG_B_W){1'b0}}, b};
  endfunction

endpackage

// File: rtl/cfgstore_timer.sv
module cfgstore_timer #(
  parameter int TICKS = 90
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(TICKS + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(TICKS);

  logic [CNT_W-1:0] left_q;
  logic             busy_q;

  assign done = busy_q && tick && (left_q == CNT_W'(1));
  assign busy = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      left_q <= LOAD;
    end else if (busy_q && tick) begin
      left_q <= left_q - CNT_W'(1);
      if (left_q == CNT_W'(1)) busy_q <= 1'b0;
    end
  end

  assert_done_ends_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  assert_busy_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (left_q != '0 && left_q <= LOAD));
endmodule

// File: rtl/cfgstore_bank.sv
module cfgstore_bank #(
  parameter int W = 96
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         erase,
  input  logic         prog,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] img
);
  // store contents survive rst_n; the initial value is the shipped state
  logic [W-1:0] img_q = '0;

  always_ff @(posedge clk) begin
    if (erase)     img_q <= '0;
    else if (prog) img_q <= img_q | wdata;
  end

  assign img = img_q;

  assert_prog_sets_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prog |=> ((img & $past(img)) == $past(img)));
  assert_prog_takes_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (prog && !erase) |=> ((img & $past(wdata)) == $past(wdata)));
  assert_erase_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> (img == '0));
  assert_idle_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!erase && !prog) |=> $stable(img));
endmodule

// File: rtl/cfgstore_ctrl.sv
module cfgstore_ctrl
  import cfgstore_pkg::*;
#(
  parameter int OP_TICKS = 90
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                cmd_valid,
  input  logic [2:0]          cmd_op,
  input  logic [IMG_A_W-1:0]  wr_image,
  output logic                busy,
  output logic                cmd_err,
  output logic                rd_valid,
  output logic                rd_blocked,
  output logic [IMG_A_W-1:0]  rd_image,
  output logic [CAP_W-1:0]    act_caps,
  output logic                act_range,
  output logic [GAIN_W-1:0]   act_gain,
  output logic                act_sel_b,
  output logic                park_out
);
  op_e op;
  assign op = op_e'(cmd_op);

  logic cmd_live, start, read_go, err_d, done, erasing;
  logic lock, wake, allow;
  op_e  pend_op;
  logic [IMG_A_W-1:0] pend_data;
  logic [IMG_A_W-1:0] img_a;
  logic [IMG_B_W-1:0] img_b;
  logic booted, sel_b;

  assign cmd_live = cmd_valid && (op != OP_NOP);
  assign start    = cmd_live && !busy && is_long(op);
  assign read_go  = cmd_live && !busy && is_read(op);
  assign err_d    = cmd_live && (busy || op == OP_BAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_op   <= OP_NOP;
      pend_data <= '0;
    end else if (start) begin
      pend_op   <= op;
      pend_data <= wr_image;
    end
  end

  cfgstore_timer #(.TICKS(OP_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
    .busy(busy), .done(done)
  );

  cfgstore_bank #(.W(IMG_A_W)) u_bank_a (
    .clk(clk), .rst_n(rst_n),
    .erase(done && pend_op == OP_ERASE_A),
    .prog (done && pend_op == OP_PROG_A),
    .wdata(pend_data),
    .img  (img_a)
  );

  cfgstore_bank #(.W(IMG_B_W)) u_bank_b (
    .clk(clk), .rst_n(rst_n),
    .erase(done && pend_op == OP_ERASE_B),
    .prog (done && pend_op == OP_PROG_B),
    .wdata(pend_data[IMG_B_W-1:0]),
    .img  (img_b)
  );

  assign lock  = img_a[LOCK_BIT];
  assign wake  = img_a[WAKE_BIT];
  assign allow = read_allowed(op, lock, wake);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      rd_blocked <= 1'b0;
      rd_image   <= '0;
      cmd_err    <= 1'b0;
    end else begin
      rd_valid   <= read_go;
      rd_blocked <= read_go && !allow;
      cmd_err    <= err_d;
      if (read_go)
        rd_image <= !allow ? '0 : (op == OP_READ_A) ? img_a : widen_b(img_b);
    end
  end

  // wake-up image choice is taken once, on the first clock after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      booted <= 1'b0;
      sel_b  <= 1'b0;
    end else if (!booted) begin
      booted <= 1'b1;
      sel_b  <= wake;
    end
  end

  assign erasing   = busy && is_erase(pend_op);
  assign act_sel_b = sel_b;
  assign act_caps  = sel_b ? img_b[CAP_W-1:0] : img_a[CAP_W-1:0];
  assign act_range = sel_b ? img_b[RANGE_BIT] : img_a[RANGE_BIT];
  assign act_gain  = erasing ? GAIN_ERASE : img_a[GAIN_LSB +: GAIN_W];
  assign park_out  = erasing;

  assert_err_on_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_live && busy) |=> cmd_err);
  assert_busy_cmd_no_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(pend_op));
  assert_park_gain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    park_out |-> (act_gain == GAIN_ERASE && busy));
  assert_lock_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && lock) |-> (rd_blocked && rd_image == '0));
  assert_wake_blocks_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (read_go && op == OP_READ_A && wake) |=> rd_blocked);
  assert_read_keeps_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
    read_go |=> ($stable(act_caps) && $stable(act_range)));
  assert_read_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid || $past(read_go));
  assert_sel_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    booted |=> $stable(sel_b));
endmodule

// File: tb/test_cfgstore_ctrl.sv
module test_cfgstore_ctrl;
  localparam int TK = 5;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [95:0] wr_image = '0;
  logic busy, cmd_err, rd_valid, rd_blocked, act_range, act_sel_b, park_out;
  logic [95:0] rd_image;
  logic [69:0] act_caps;
  logic [1:0] act_gain;

  int n_run = 0, n_fail = 0;
  logic [95:0] ma = '0;
  logic [70:0] mb = '0;
  logic msel = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cfgstore_ctrl #(.OP_TICKS(TK)) i_cfgstore_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .wr_image(wr_image), .busy(busy), .cmd_err(cmd_err), .rd_valid(rd_valid),
    .rd_blocked(rd_blocked), .rd_image(rd_image), .act_caps(act_caps),
    .act_range(act_range), .act_gain(act_gain), .act_sel_b(act_sel_b),
    .park_out(park_out)
  );

  task automatic chk(bit ok, string req, logic [95:0] act, logic [95:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [69:0] exp_caps();
    return msel ? mb[69:0] : ma[69:0];
  endfunction

  function automatic logic [95:0] exp_read(logic is_a, output logic blk);
    blk = ma[95] || (is_a && ma[94]);
    if (blk) return '0;
    return is_a ? ma : {25'd0, mb};
  endfunction

  task automatic chk_active(string req);
    chk(act_caps == exp_caps(), {req, " caps"}, 96'(act_caps), 96'(exp_caps()));
    chk(act_range == (msel ? mb[70] : ma[70]), {req, " range"},
        96'(act_range), 96'(msel ? mb[70] : ma[70]));
    chk(act_gain == ma[93:92] && !park_out, {req, " gain/park idle"},
        {act_gain, park_out}, {ma[93:92], 1'b0});
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    msel = ma[94];
  endtask

  task automatic do_long(logic [2:0] op, logic [95:0] data, bit inject);
    bit er;
    er = (op == 3'd1) || (op == 3'd2);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = op; wr_image = data;
    @(negedge clk); cmd_valid = 1'b0; wr_image = '0;
    chk(busy == 1'b1, "R4 busy rises", 96'(busy), 96'd1);
    if (er) chk(act_gain == 2'b11 && park_out, "R6 erase gain/park",
                {act_gain, park_out}, {2'b11, 1'b1});
    for (int k = 1; k <= TK; k++) begin
      if (inject && k == 2) begin
        cmd_valid = 1'b1; cmd_op = 3'd3; wr_image = '1;
        @(negedge clk); cmd_valid = 1'b0; wr_image = '0;
        chk(cmd_err == 1'b1, "R5 err pulse while busy", 96'(cmd_err), 96'd1);
        @(negedge clk);
        chk(cmd_err == 1'b0, "R5 err one cycle", 96'(cmd_err), 96'd0);
      end
      tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      chk(busy == (k < TK), "R4 busy length", 96'(busy), 96'(k < TK));
      if (k < TK && er) chk(park_out == 1'b1, "R6 park held", 96'(park_out), 96'd1);
    end
    case (op)
      3'd1: ma = '0;
      3'd2: mb = '0;
      3'd3: ma = ma | data;
      3'd4: mb = mb | data[70:0];
      default: ;
    endcase
    chk_active("R6 R10 after op");
  endtask

  task automatic do_read(bit is_a, string req);
    logic blk;
    logic [95:0] e;
    logic [69:0] caps0;
    e = exp_read(is_a, blk);
    caps0 = act_caps;
    @(negedge clk); cmd_valid = 1'b1; cmd_op = is_a ? 3'd5 : 3'd6;
    @(negedge clk); cmd_valid = 1'b0;
    chk(rd_valid == 1'b1, {req, " R9 rd_valid"}, 96'(rd_valid), 96'd1);
    chk(rd_image == e, {req, " image"}, rd_image, e);
    chk(rd_blocked == blk, {req, " blocked"}, 96'(rd_blocked), 96'(blk));
    chk(act_caps == caps0, "R9 active unchanged", 96'(act_caps), 96'(caps0));
    @(negedge clk);
    chk(rd_valid == 1'b0, "R9 rd_valid one cycle", 96'(rd_valid), 96'd0);
  endtask

  initial begin
    logic [95:0] p1, p2, d;
    void'($urandom(32'd4021));
    p1 = {2'b00, 2'b01, 21'h15A5A, 1'b1, 70'h2A_5555_0000_FFFF_1234};
    p2 = {2'b00, 2'b10, 21'h00F00, 1'b0, 70'h01_0000_8888_0000_4321};
    do_reset();
    // R1 reset state
    chk({busy, cmd_err, rd_valid, rd_blocked, park_out} == 5'b0, "R1 reset outputs",
        96'({busy, cmd_err, rd_valid, rd_blocked, park_out}), 96'd0);
    chk_active("R1 idle");
    do_read(1'b1, "R1 shipped A");
    do_read(1'b0, "R1 shipped B");
    // R5 nop and undefined opcode
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 3'd0;
    @(negedge clk); cmd_valid = 1'b0;
    chk(!cmd_err && !busy && !rd_valid, "R5 nop inert", 96'({cmd_err, busy, rd_valid}), 96'd0);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 3'd7;
    @(negedge clk); cmd_valid = 1'b0;
    chk(cmd_err && !busy, "R5 undefined opcode", 96'({cmd_err, busy}), 96'b10);
    // R2 programming ORs
    do_long(3'd3, p1, 1'b0);
    do_read(1'b1, "R2 prog A");
    do_long(3'd3, p2, 1'b1);
    do_read(1'b1, "R2 R5 OR into A, busy cmd ignored");
    do_long(3'd4, {25'h1FFFFFF, 71'h55_AAAA_0000_1111_2222}, 1'b0);
    do_read(1'b0, "R2 prog B upper ignored");
    // R3 erase B leaves A
    do_long(3'd2, '0, 1'b0);
    do_read(1'b0, "R3 B erased");
    do_read(1'b1, "R3 A untouched");
    do_long(3'd4, {25'd0, 71'h7F_0F0F_F0F0_1357_9BDF}, 1'b0);
    // R8 wake select blocks A
    do_long(3'd3, 96'd1 << 94, 1'b0);
    do_read(1'b1, "R8 A refused");
    do_read(1'b0, "R8 B allowed");
    // R10 boot picks B
    do_reset();
    chk(act_sel_b == 1'b1, "R10 sel B latched", 96'(act_sel_b), 96'd1);
    chk_active("R10 B active");
    do_long(3'd1, '0, 1'b1);
    chk(act_sel_b == 1'b1, "R10 sel held", 96'(act_sel_b), 96'd1);
    do_read(1'b1, "R3 A erased");
    do_reset();
    chk(act_sel_b == 1'b0, "R10 sel A latched", 96'(act_sel_b), 96'd0);
    // R7 lock
    do_long(3'd3, p1 | (96'd1 << 95), 1'b0);
    do_read(1'b1, "R7 lock A");
    do_read(1'b0, "R7 lock B");
    do_long(3'd2, '0, 1'b0);
    do_read(1'b0, "R7 still locked after erase B");
    do_long(3'd1, '0, 1'b0);
    do_read(1'b1, "R7 unlocked by erase A");
    // random mix
    for (int i = 0; i < 60; i++) begin
      int r;
      r = int'($urandom_range(0, 9));
      d = {$urandom(), $urandom(), $urandom()};
      if ($urandom_range(0, 7) != 0) d[95] = 1'b0;
      if ($urandom_range(0, 3) != 0) d[94] = 1'b0;
      case (r)
        0: do_long(3'd1, '0, 1'b0);
        1: do_long(3'd2, '0, 1'b0);
        2, 3: do_long(3'd3, d, r == 3);
        4, 5: do_long(3'd4, d, 1'b0);
        6, 7: do_read(1'b1, "R9 random read A");
        8: do_read(1'b0, "R9 random read B");
        default: begin do_reset(); chk_active("R10 random reset"); end
      endcase
    end
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule